// File: doc/BRIEF.md
# SPI Master with Latched Completion Interrupt

This block is an 8-bit serial peripheral interface master that sits behind a small register bus. Software sets the clock polarity, clock phase and bit order in a control register and the serial clock period in a clock-count register. Writing the data register starts a transfer. The block then produces the serial clock from its own clock, launches transmit bits on the output data line and samples the input data line. Once the last bit has been shifted, the received byte is available in the data register.

Completion is reported in two places. A status flag is cleared by reading the status register and then the data register. A separate interrupt request is cleared only by writing the interrupt register. The request is armed only when the status flag goes from low to high. If a new transfer completes between the data read and the interrupt write, the status flag stays set and no further interrupt is raised. The block keeps this behaviour on purpose, so that software which services the flag late shows the same lost-interrupt symptom.

The slave-select input must be held high for the master to drive its pins. If it is seen low during a transfer, the transfer stops and a mode-fault status bit is set.

Top module: `spi_master_irq`

## Requirements
- R1: The clock-count register is at address 1 and resets to 8. The serial clock high and low phases each last half of the effective count, rounded down. A transfer takes 16 such half periods. The done flag and the interrupt become visible 16*half clock edges after the edge that accepts the data write.
- R2: A clock-count value below 8 behaves exactly as 8. Odd values are rounded down to the next even value.
- R3: When all 8 bits have been shifted, status bit 0 (done) sets and status bit 3 (busy) clears. Status is at address 3.
- R4: Done clears only after a read of status while done is set, followed by a read of the data register (address 2). A data read without that earlier status read leaves done set.
- R5: The interrupt output clears only when 1 is written to bit 0 of the interrupt register (address 4). That write does not change done.
- R6: The interrupt sets only when done goes from 0 to 1. A transfer that completes while done is already set does not raise it.
- R7: While slave select is low, both output enables are low. If slave select is low during a transfer, the transfer aborts without setting done, and status bit 2 (mode fault) sets. Mode fault keeps the enables low until a status read clears it.
- R8: Control register bits are at address 0: bit 0 is polarity, bit 1 is phase, bit 2 is bit order. The serial clock rests at the polarity level. Input data is sampled on the rising clock edge when polarity equals phase, and on the falling edge otherwise. Each transfer has exactly 8 sampling edges.
- R9: With control bit 2 clear, bits go out MSB first. With it set, they go out LSB first.
- R10: A data write during a transfer is ignored: the byte in flight is unchanged. Such a write sets status bit 1 (write collision), which a status read clears.
- R11: The byte sampled on the input data line is returned by a data register read after completion.
- R12: After reset, status and the interrupt are 0, the clock rests low, and both output enables are high while slave select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 3 | Register address |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe (has clear side effects) |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, combinational from address |
| ssIn | input | 1 | Slave select, must be high for master operation |
| miso | input | 1 | Serial input data |
| sckOut | output | 1 | Serial clock |
| sckOe | output | 1 | Serial clock output enable |
| mosiOut | output | 1 | Serial output data |
| mosiOe | output | 1 | Serial output data enable |
| irq | output | 1 | Latched completion interrupt |

## Verification
The bench builds the block with its default values: 8 data bits, an 8-bit clock count and a minimum count of 8. With these values every transfer lasts 64 to 160 cycles. That keeps all four clock modes, both bit orders, the forced minimum and an odd count inside one short table walk. The short transfers also make the late-service race easy to reach: the bench starts a second transfer between the data read and the interrupt write. It also covers a collision write in the middle of a transfer and a slave-select drop partway through.

// File: rtl/spi_pkg.sv
package spi_pkg;

  localparam logic [2:0] ADDR_CTRL = 3'd0;
  localparam logic [2:0] ADDR_CLK  = 3'd1;
  localparam logic [2:0] ADDR_DATA = 3'd2;
  localparam logic [2:0] ADDR_STAT = 3'd3;
  localparam logic [2:0] ADDR_INT  = 3'd4;

  // Strobes from control to datapath
  typedef struct packed {
    logic start;   // transfer accepted this cycle
    logic launch;  // present next transmit bit
    logic sample;  // capture serial input
    logic toggle;  // flip serial clock
    logic finish;  // last edge of transfer
    logic abort;   // select dropped mid transfer
    logic active;  // transfer in progress
  } spiStrobe_t;

endpackage

// File: rtl/spi_ctrl.sv
module spi_ctrl
  import spi_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int CNT_W   = 8,
  parameter int MIN_CNT = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [DATA_W-1:0] rxData,
  input  logic              ssIn,
  output spiStrobe_t        strb,
  output logic              cpol,
  output logic              cpha,
  output logic              lsbFirst,
  output logic              modeFault,
  output logic              irq
);

  localparam int EDGE_W = $clog2(2 * DATA_W);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(2 * DATA_W - 1);
  localparam logic [CNT_W-1:0]  MIN_VAL   = CNT_W'(MIN_CNT);

  logic [CNT_W-1:0]  clkCntReg, effCnt, halfCnt, divCnt;
  logic [EDGE_W-1:0] edgeCnt;
  logic busy, doneFlag, seenFlag, wcolFlag, irqPending;
  logic wrCtrl, wrClk, wrData, wrInt, rdData, rdStat;
  logic startReq, abortReq, tick, lastEdge;

  assign wrCtrl = busWr && (busAddr == ADDR_CTRL);
  assign wrClk  = busWr && (busAddr == ADDR_CLK);
  assign wrData = busWr && (busAddr == ADDR_DATA);
  assign wrInt  = busWr && (busAddr == ADDR_INT);
  assign rdData = busRd && (busAddr == ADDR_DATA);
  assign rdStat = busRd && (busAddr == ADDR_STAT);

  // Effective count: floor at minimum, half phase drops the odd bit
  assign effCnt  = (clkCntReg < MIN_VAL) ? MIN_VAL : clkCntReg;
  assign halfCnt = effCnt >> 1;

  assign startReq = wrData && !busy && ssIn && !modeFault;
  assign abortReq = busy && !ssIn;
  assign tick     = busy && !abortReq && (divCnt == halfCnt - 1'b1);
  assign lastEdge = (edgeCnt == LAST_EDGE);

  always_comb begin
    strb        = '0;
    strb.start  = startReq;
    strb.toggle = tick;
    strb.sample = tick && (edgeCnt[0] == cpha);
    strb.launch = tick && !lastEdge && (edgeCnt[0] != cpha);
    strb.finish = tick && lastEdge;
    strb.abort  = abortReq;
    strb.active = busy;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cpol      <= 1'b0;
      cpha      <= 1'b0;
      lsbFirst  <= 1'b0;
      clkCntReg <= MIN_VAL;
    end else begin
      if (wrCtrl) begin
        cpol     <= busWdata[0];
        cpha     <= busWdata[1];
        lsbFirst <= busWdata[2];
      end
      if (wrClk) clkCntReg <= busWdata[CNT_W-1:0];
    end
  end

  // Sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      divCnt  <= '0;
      edgeCnt <= '0;
    end else if (startReq) begin
      busy    <= 1'b1;
      divCnt  <= '0;
      edgeCnt <= '0;
    end else if (busy) begin
      if (abortReq || (tick && lastEdge)) busy <= 1'b0;
      if (tick) begin
        divCnt  <= '0;
        edgeCnt <= edgeCnt + 1'b1;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  // Flags: set events win over clears in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneFlag   <= 1'b0;
      seenFlag   <= 1'b0;
      wcolFlag   <= 1'b0;
      modeFault  <= 1'b0;
      irqPending <= 1'b0;
    end else begin
      if (strb.finish) doneFlag <= 1'b1;
      else if (rdData && seenFlag) doneFlag <= 1'b0;

      if (rdStat && doneFlag) seenFlag <= 1'b1;
      else if (rdData) seenFlag <= 1'b0;

      if (wrData && busy) wcolFlag <= 1'b1;
      else if (rdStat) wcolFlag <= 1'b0;

      if (abortReq) modeFault <= 1'b1;
      else if (rdStat) modeFault <= 1'b0;

      if (strb.finish && !doneFlag) irqPending <= 1'b1;
      else if (wrInt && busWdata[0]) irqPending <= 1'b0;
    end
  end

  assign irq = irqPending;

  always_comb begin
    busRdata = '0;
    unique case (busAddr)
      ADDR_CTRL: busRdata[2:0] = {lsbFirst, cpha, cpol};
      ADDR_CLK:  busRdata[CNT_W-1:0] = clkCntReg;
      ADDR_DATA: busRdata = rxData;
      ADDR_STAT: busRdata[3:0] = {busy, modeFault, wcolFlag, doneFlag};
      ADDR_INT:  busRdata[0] = irqPending;
      default:   busRdata = '0;
    endcase
  end

  // Assertions
  p_half_floor_r2: assert property (@(posedge clk) disable iff (!rstN)
    halfCnt >= CNT_W'(MIN_CNT / 2));

  p_irq_from_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqPending) |-> $rose(doneFlag));

  p_irq_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (irqPending && !(wrInt && busWdata[0])) |=> irqPending);

  p_done_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(doneFlag) |-> $past(rdData && seenFlag));

  p_wcol_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && wrData) |=> wcolFlag);

  p_abort_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !ssIn) |=> (modeFault && !busy));

endmodule

// File: rtl/spi_datapath.sv
module spi_datapath
  import spi_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  spiStrobe_t        strb,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              lsbFirst,
  input  logic [DATA_W-1:0] txIn,
  input  logic              miso,
  output logic              sckOut,
  output logic              mosiOut,
  output logic [DATA_W-1:0] rxData
);

  logic [DATA_W-1:0] txShift, rxShift, rxNext;
  logic              sckReg, mosiReg;

  function automatic logic headBit(input logic [DATA_W-1:0] v, input logic lsb);
    return lsb ? v[0] : v[DATA_W-1];
  endfunction

  function automatic logic [DATA_W-1:0] advance(input logic [DATA_W-1:0] v, input logic lsb);
    return lsb ? {1'b0, v[DATA_W-1:1]} : {v[DATA_W-2:0], 1'b0};
  endfunction

  assign rxNext = lsbFirst ? {miso, rxShift[DATA_W-1:1]}
                           : {rxShift[DATA_W-2:0], miso};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckReg <= 1'b0;
    end else if (!strb.active || strb.abort) begin
      sckReg <= cpol;
    end else if (strb.toggle) begin
      sckReg <= ~sckReg;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      mosiReg <= 1'b0;
    end else if (strb.start) begin
      if (!cpha) begin
        mosiReg <= headBit(txIn, lsbFirst);
        txShift <= advance(txIn, lsbFirst);
      end else begin
        txShift <= txIn;
      end
    end else if (strb.launch) begin
      mosiReg <= headBit(txShift, lsbFirst);
      txShift <= advance(txShift, lsbFirst);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      rxData  <= '0;
    end else begin
      if (strb.start) rxShift <= '0;
      else if (strb.sample) rxShift <= rxNext;
      if (strb.finish) rxData <= strb.sample ? rxNext : rxShift;
    end
  end

  assign sckOut  = sckReg;
  assign mosiOut = mosiReg;

  p_sck_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.active && $past(!strb.active)) |-> (sckReg == $past(cpol)));

endmodule

// File: rtl/spi_master_irq.sv
module spi_master_irq
  import spi_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int CNT_W   = 8,
  parameter int MIN_CNT = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              ssIn,
  input  logic              miso,
  output logic              sckOut,
  output logic              sckOe,
  output logic              mosiOut,
  output logic              mosiOe,
  output logic              irq
);

  spiStrobe_t        strb;
  logic              cpol, cpha, lsbFirst, modeFault;
  logic [DATA_W-1:0] rxData;

  spi_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W), .MIN_CNT(MIN_CNT)) uCtrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .rxData(rxData), .ssIn(ssIn),
    .strb(strb), .cpol(cpol), .cpha(cpha), .lsbFirst(lsbFirst),
    .modeFault(modeFault), .irq(irq)
  );

  spi_datapath #(.DATA_W(DATA_W)) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .cpol(cpol), .cpha(cpha),
    .lsbFirst(lsbFirst), .txIn(busWdata), .miso(miso), .sckOut(sckOut),
    .mosiOut(mosiOut), .rxData(rxData)
  );

  assign sckOe  = ssIn && !modeFault;
  assign mosiOe = ssIn && !modeFault;

endmodule

// File: tb/tb_spi_master_irq.sv
module tb_spi_master_irq;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] busAddr = '0;
  logic       busWr = 1'b0, busRd = 1'b0;
  logic [7:0] busWdata = '0, busRdata;
  logic       ssIn = 1'b1, miso;
  logic       sckOut, sckOe, mosiOut, mosiOe, irq;
  logic       forceMiso = 1'b0, forceVal = 1'b0;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;
  assign miso = forceMiso ? forceVal : mosiOut;

  spi_master_irq dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .ssIn(ssIn), .miso(miso),
    .sckOut(sckOut), .sckOe(sckOe), .mosiOut(mosiOut), .mosiOe(mosiOe), .irq(irq)
  );

  // Sampling-edge monitor: rising edge when polarity equals phase
  logic       monPol = 1'b0, monPha = 1'b0;
  logic [7:0] capBits = '0;
  int         capCount = 0;
  always @(sckOut) begin
    if (sckOut == (monPol == monPha)) begin
      capBits  = {capBits[6:0], mosiOut};
      capCount = capCount + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    #1 d = busRdata;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  // Returns cycles counted from the accepting edge until irq seen
  task automatic waitIrq(output int n);
    n = 1;
    while (!irq && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  function automatic int expCycles(input logic [7:0] c);
    int eff;
    eff = (c < 8) ? 8 : int'(c);
    return 16 * (eff / 2) + 1;
  endfunction

  function automatic logic [7:0] rev8(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7 - i];
    return r;
  endfunction

  // {cpol, cpha, lsbFirst, clkCount, txByte}
  localparam int NVEC = 6;
  localparam logic [18:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 1'b0, 8'd8,  8'hA5},
    {1'b0, 1'b1, 1'b0, 8'd11, 8'h3C},
    {1'b1, 1'b0, 1'b1, 8'd3,  8'h81},
    {1'b1, 1'b1, 1'b1, 8'd20, 8'h5E},
    {1'b0, 1'b0, 1'b1, 8'd9,  8'hC3},
    {1'b1, 1'b1, 1'b0, 8'd0,  8'h7F}
  };

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R12 reset state
    check(irq == 1'b0, "R12 irq", irq, 0);
    check(sckOut == 1'b0, "R12 sck idle", sckOut, 0);
    check(sckOe && mosiOe, "R12 enables", {sckOe, mosiOe}, 3);
    busRead(3'd3, rd);
    check(rd == 8'h00, "R12 status", rd, 0);
    busRead(3'd1, rd);
    check(rd == 8'd8, "R1 clk reset", rd, 8);

    // Table walk
    for (int v = 0; v < NVEC; v++) begin
      logic cp, ch, lf;
      logic [7:0] ck, tx;
      {cp, ch, lf, ck, tx} = VEC[v];
      busWrite(3'd0, {5'b0, lf, ch, cp});
      busWrite(3'd1, ck);
      monPol = cp; monPha = ch;
      @(negedge clk);
      capCount = 0; capBits = '0;
      busWrite(3'd2, tx);
      waitIrq(n);
      check(n == expCycles(ck), "R1 R2 transfer cycles", n, expCycles(ck));
      check(capCount == 8, "R8 sampling edges", capCount, 8);
      check(capBits == (lf ? rev8(tx) : tx), "R9 bit order", capBits, lf ? rev8(tx) : tx);
      @(negedge clk);
      check(sckOut == cp, "R8 idle level", sckOut, cp);
      busRead(3'd3, rd);
      check(rd[3:0] == 4'b0001, "R3 status done", rd, 1);
      busRead(3'd2, rd);
      check(rd == tx, "R11 rx loopback", rd, tx);
      busRead(3'd3, rd);
      check(rd[0] == 1'b0, "R4 done cleared", rd, 0);
      check(irq == 1'b1, "R5 irq kept by reads", irq, 1);
      busWrite(3'd4, 8'h01);
      check(irq == 1'b0, "R5 irq cleared", irq, 0);
    end

    // R11 constant input line
    busWrite(3'd0, 8'h00);
    busWrite(3'd1, 8'd8);
    forceMiso = 1'b1; forceVal = 1'b1;
    busWrite(3'd2, 8'h00);
    waitIrq(n);
    busRead(3'd3, rd);
    busRead(3'd2, rd);
    check(rd == 8'hFF, "R11 rx from line", rd, 8'hFF);
    busWrite(3'd4, 8'h01);
    forceMiso = 1'b0;

    // R10 collision write
    busWrite(3'd2, 8'h96);
    repeat (10) @(negedge clk);
    busWrite(3'd2, 8'h11);
    waitIrq(n);
    busRead(3'd3, rd);
    check(rd[1:0] == 2'b11, "R10 collision flag", rd, 3);
    busRead(3'd2, rd);
    check(rd == 8'h96, "R10 write ignored", rd, 8'h96);
    busRead(3'd3, rd);
    check(rd[1:0] == 2'b00, "R10 flag read clear", rd, 0);
    busWrite(3'd4, 8'h01);

    // R4 data read alone does not clear done
    busWrite(3'd2, 8'h42);
    waitIrq(n);
    busRead(3'd2, rd);
    busRead(3'd3, rd);
    check(rd[0] == 1'b1, "R4 data read alone", rd, 1);
    busRead(3'd2, rd);
    busRead(3'd3, rd);
    check(rd[0] == 1'b0, "R4 sequence clears", rd, 0);
    busWrite(3'd4, 8'h01);

    // R5 R6 late-service race
    busWrite(3'd2, 8'h01);
    waitIrq(n);
    busRead(3'd3, rd);
    busRead(3'd2, rd);
    busWrite(3'd2, 8'h02);
    repeat (80) @(negedge clk);
    check(irq == 1'b1, "R6 irq still pending", irq, 1);
    busWrite(3'd4, 8'h01);
    check(irq == 1'b0, "R5 irq write clear", irq, 0);
    busRead(3'd3, rd);
    check(rd[0] == 1'b1, "R5 done untouched", rd, 1);
    busWrite(3'd2, 8'h03);
    repeat (80) @(negedge clk);
    check(irq == 1'b0, "R6 no new irq", irq, 0);
    busRead(3'd3, rd);
    busRead(3'd2, rd);
    busWrite(3'd4, 8'h01);

    // R7 select dropped mid transfer
    busWrite(3'd2, 8'hF0);
    repeat (20) @(negedge clk);
    ssIn = 1'b0;
    @(negedge clk);
    check(!sckOe && !mosiOe, "R7 enables off", {sckOe, mosiOe}, 0);
    ssIn = 1'b1;
    repeat (80) @(negedge clk);
    check(!sckOe, "R7 fault holds off", sckOe, 0);
    check(irq == 1'b0, "R7 no irq", irq, 0);
    busRead(3'd3, rd);
    check(rd[3:0] == 4'b0100, "R7 mode fault status", rd, 4);
    @(negedge clk);
    check(sckOe && mosiOe, "R7 enables restored", {sckOe, mosiOe}, 3);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule